// File: doc/BRIEF.md
# Cache Fill Insertion Position Estimator

This block decides what happens to a line that is about to be filled into a 16-way last-level cache. There are two outcomes. The fill can be dropped, which is a bypass. Otherwise the line is placed at a position in the recency stack, where position 0 is the most-recently-used end and position 15 is the least-recently-used end. The decision draws on three sources of information:

- a flag that says the zone tracker has seen the line used before;
- an access count and a reuse count kept for the surrounding memory zone;
- a reuse class attached to the instruction that caused the miss.

The position starts at the least-recently-used end. Each piece of evidence that the line will be reused moves it toward the most-recently-used end, by halving it or by overriding it.

Inputs are taken on a valid strobe. The bypass flag and the 4-bit position appear on the next clock edge, together with an output valid. The block does not reorder the stack and does not choose between competing policies.

Top module: `fill_insert_estimator`

## Requirements
- R1: While reset is active and after it is released, with no input yet accepted, out_valid is 0, out_bypass is 0 and out_pos is 15.
- R2: A sample taken with in_valid high produces out_valid high exactly one clock later. A cycle with in_valid low produces out_valid low one clock later.
- R3: An instruction class of 0 (skip) sets out_bypass.
- R4: out_bypass is set when acc_cnt is strictly greater than 16 times reuse_cnt. The product is formed without overflow for every count value, so acc_cnt equal to 16 times reuse_cnt does not bypass.
- R5: Whenever out_bypass is 1, out_pos is 15.
- R6: For a fill that is not bypassed, the position starts at 15 and is halved (integer division) when map_reuse is 1.
- R7: After the R6 step, the position is halved again when reuse_cnt is strictly greater than acc_cnt. Equal counts leave it unchanged.
- R8: Class 4 (hot) forces the position to 0. This is applied after the R6 and R7 steps.
- R9: Class 3 (warm) halves the position that results from the R6 and R7 steps.
- R10: Class 1 (dead) forces the position to 15, whatever the R6 and R7 steps produced.
- R11: Class 2 (plain) and the unused codes 5, 6 and 7 leave the position that results from the R6 and R7 steps unchanged.
- R12: While in_valid is low, out_bypass and out_pos keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample the inputs on this cycle |
| map_reuse | input | 1 | Zone tracker reports the line was touched before |
| acc_cnt | input | CNT_W | Zone access count |
| reuse_cnt | input | CNT_W | Zone reuse count |
| in_class | input | 3 | Instruction reuse class (0 skip, 1 dead, 2 plain, 3 warm, 4 hot) |
| out_valid | output | 1 | Decision valid |
| out_bypass | output | 1 | Drop the fill |
| out_pos | output | 4 | Insertion position, 0 = MRU end, 15 = LRU end |

## Verification
There is a single register stage and no other state. A wrong next value therefore shows up at the ports exactly one cycle after the sample that caused it. An error in the halving order shows as a position off by one halving step, for example 7 where 3 is expected. An overflow in the scaled reuse count shows as a spurious bypass when the reuse count is large. A fault in the hold path shows as a changed position on a cycle with no input. Each scenario therefore compares the outputs one edge after its sample, and again after idle cycles.

// File: rtl/fill_est_pkg.sv
package fill_est_pkg;

    localparam int POS_W = 4;
    localparam logic [POS_W-1:0] POS_LRU = 4'd15;
    localparam logic [POS_W-1:0] POS_MRU = 4'd0;

    typedef enum logic [2:0] {
        CLS_SKIP  = 3'd0,
        CLS_DEAD  = 3'd1,
        CLS_PLAIN = 3'd2,
        CLS_WARM  = 3'd3,
        CLS_HOT   = 3'd4
    } iclass_e;

    typedef struct packed {
        logic             vld;
        logic             byp;
        logic [POS_W-1:0] pos;
    } est_state_t;

endpackage

// File: rtl/fill_bypass_judge.sv
module fill_bypass_judge
    import fill_est_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SCALE_SH = 4
) (
    input  logic [CNT_W-1:0] acc_cnt,
    input  logic [CNT_W-1:0] reuse_cnt,
    input  logic [2:0]       cls,
    output logic             bypass
);
    localparam int WIDE_W = CNT_W + SCALE_SH;

    logic [WIDE_W-1:0] acc_wide;
    logic [WIDE_W-1:0] reuse_scaled;
    logic              sparse_reuse;
    logic              skip_cls;

    always_comb begin
        acc_wide     = {{SCALE_SH{1'b0}}, acc_cnt};
        reuse_scaled = {reuse_cnt, {SCALE_SH{1'b0}}};
        sparse_reuse = acc_wide > reuse_scaled;
        skip_cls     = (cls == CLS_SKIP);
        bypass       = skip_cls || sparse_reuse;
    end

endmodule

// File: rtl/fill_slot_calc.sv
module fill_slot_calc
    import fill_est_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             map_reuse,
    input  logic [CNT_W-1:0] acc_cnt,
    input  logic [CNT_W-1:0] reuse_cnt,
    input  logic [2:0]       cls,
    output logic [POS_W-1:0] pos
);
    logic [POS_W-1:0] step_map;
    logic [POS_W-1:0] step_zone;

    always_comb begin
        step_map  = map_reuse ? (POS_LRU >> 1) : POS_LRU;
        step_zone = (reuse_cnt > acc_cnt) ? (step_map >> 1) : step_map;
        unique case (cls)
            CLS_HOT:  pos = POS_MRU;
            CLS_WARM: pos = step_zone >> 1;
            CLS_DEAD: pos = POS_LRU;
            default:  pos = step_zone;
        endcase
    end

endmodule

// File: rtl/fill_insert_estimator.sv
module fill_insert_estimator
    import fill_est_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             map_reuse,
    input  logic [CNT_W-1:0] acc_cnt,
    input  logic [CNT_W-1:0] reuse_cnt,
    input  logic [2:0]       in_class,
    output logic             out_valid,
    output logic             out_bypass,
    output logic [3:0]       out_pos
);
    logic             byp_w;
    logic [POS_W-1:0] pos_w;
    est_state_t       st_d;
    est_state_t       st_q;

    fill_bypass_judge #(.CNT_W(CNT_W), .SCALE_SH(4)) u_judge (
        .acc_cnt   (acc_cnt),
        .reuse_cnt (reuse_cnt),
        .cls       (in_class),
        .bypass    (byp_w)
    );

    fill_slot_calc #(.CNT_W(CNT_W)) u_slot (
        .map_reuse (map_reuse),
        .acc_cnt   (acc_cnt),
        .reuse_cnt (reuse_cnt),
        .cls       (in_class),
        .pos       (pos_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.byp = byp_w;
            st_d.pos = byp_w ? POS_LRU : pos_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.byp <= 1'b0;
            st_q.pos <= POS_LRU;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_bypass = st_q.byp;
    assign out_pos    = st_q.pos;

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_skip_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_SKIP) |=> out_bypass);
    a_r5_bypass_lru: assert property (@(posedge clk) disable iff (!rst_n)
        out_bypass |-> (out_pos == POS_LRU));
    a_r8_hot_mru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_HOT && reuse_cnt >= acc_cnt)
        |=> (!out_bypass && out_pos == POS_MRU));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_pos) && $stable(out_bypass)));

endmodule

// File: tb/tb_fill_insert_estimator.sv
module tb_fill_insert_estimator;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             map_reuse = 1'b0;
    logic [CNT_W-1:0] acc_cnt = '0;
    logic [CNT_W-1:0] reuse_cnt = '0;
    logic [2:0]       in_class = 3'd2;
    logic             out_valid;
    logic             out_bypass;
    logic [3:0]       out_pos;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    fill_insert_estimator #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .map_reuse(map_reuse),
        .acc_cnt(acc_cnt), .reuse_cnt(reuse_cnt), .in_class(in_class),
        .out_valid(out_valid), .out_bypass(out_bypass), .out_pos(out_pos)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_byp(int a, int r, int c);
        return (c == 0 || a > 16 * r) ? 1 : 0;
    endfunction

    function automatic int exp_pos(int m, int a, int r, int c);
        int p = 15;
        if (exp_byp(a, r, c) == 1) return 15;
        if (m != 0) p = p / 2;
        if (r > a) p = p / 2;
        if (c == 4) p = 0;
        else if (c == 3) p = p / 2;
        else if (c == 1) p = 15;
        return p;
    endfunction

    task automatic apply(input string req, input int m, input int a, input int r, input int c);
        @(negedge clk);
        in_valid  = 1'b1;
        map_reuse = m[0];
        acc_cnt   = a[CNT_W-1:0];
        reuse_cnt = r[CNT_W-1:0];
        in_class  = c[2:0];
        @(negedge clk);
        in_valid  = 1'b0;
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " bypass"}, int'(out_bypass), exp_byp(a, r, c));
        check({req, " pos"}, int'(out_pos), exp_pos(m, a, r, c));
    endtask

    task automatic t_reset();
        check("R1 valid", int'(out_valid), 0);
        check("R1 bypass", int'(out_bypass), 0);
        check("R1 pos", int'(out_pos), 15);
    endtask

    task automatic t_latency();
        @(negedge clk);
        check("R2 idle", int'(out_valid), 0);
        apply("R2", 0, 1, 1, 2);
        @(negedge clk);
        check("R2 drop", int'(out_valid), 0);
    endtask

    task automatic t_bypass();
        apply("R3", 1, 1, 5, 0);
        apply("R4 over", 0, 161, 10, 4);
        apply("R4 equal", 0, 160, 10, 2);
        apply("R4 wide", 0, 250, 255, 2);
        apply("R4 zero", 0, 1, 0, 4);
        apply("R5", 1, 200, 1, 3);
    endtask

    task automatic t_halving();
        apply("R6 none", 0, 5, 5, 2);
        apply("R6 map", 1, 5, 5, 2);
        apply("R7 both", 1, 4, 9, 2);
        apply("R7 zone", 0, 4, 9, 2);
        apply("R7 eq", 1, 9, 9, 2);
    endtask

    task automatic t_classes();
        apply("R8", 0, 20, 3, 4);
        apply("R9 a", 0, 5, 5, 3);
        apply("R9 b", 1, 4, 9, 3);
        apply("R10", 1, 4, 9, 1);
        apply("R11 five", 1, 5, 5, 5);
        apply("R11 seven", 0, 4, 9, 7);
    endtask

    task automatic t_hold();
        apply("R12 set", 1, 4, 9, 2);
        @(negedge clk);
        map_reuse = 1'b0;
        acc_cnt   = 8'd200;
        reuse_cnt = 8'd0;
        in_class  = 3'd1;
        repeat (3) @(negedge clk);
        check("R12 pos", int'(out_pos), 3);
        check("R12 bypass", int'(out_bypass), 0);
        check("R12 valid", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_bypass();
        t_halving();
        t_classes();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule